// File: doc/BRIEF.md
# Privilege-Aware Address Match Unit

This unit watches a core's instruction fetch stream and its load/store stream and compares both against a small set of programmed triggers. Each trigger has a control word and a base address word, both supplied by the trigger register bank. A trigger can select any mix of the three privilege levels and any mix of the three access kinds: fetch, read and write. When a trigger matches, the unit raises a breakpoint request. The request is meant to stop the access before it commits.

An execute trigger fires when the fetch address equals its base exactly. A read or write trigger watches a window of bytes that starts at its base. The window width comes from a size code in the control word. A data access hits the window when any of its bytes falls inside it.

The result is held in a three-state machine: `ST_IDLE` (no hit), `ST_FETCH_HIT` and `ST_DATA_HIT`. Each cycle the machine moves to `ST_FETCH_HIT` if any fetch match exists. Otherwise it moves to `ST_DATA_HIT` if any data match exists. Otherwise it moves to `ST_IDLE`. Every state can reach every state in one cycle. The winning trigger is stored next to the state as a one-hot vector.

Top module: `trig_match_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `hit_valid` and `hit_fetch` are 0 and `hit_trig` is all zeros.
- R2: A trigger can match only if its control word has at least one privilege bit set (bits 3, 4, 6) and at least one access bit set (bit 0 read, bit 1 write, bit 2 execute).
- R3: A trigger matches only if the control bit for the current privilege is set. Privilege code 0 uses bit 3, code 1 uses bit 4 and code 3 uses bit 6. Privilege code 2 never matches.
- R4: A trigger with bit 2 set matches a valid fetch only when the fetch address equals its base word exactly.
- R5: Bit 0 enables matching of data reads (`data_write`=0). Bit 1 enables matching of data writes (`data_write`=1). An access whose kind is not enabled does not match.
- R6: The window width comes from the 4-bit size code {ctrl[22:21], ctrl[17:16]}. Code 1 gives 1 byte, code 2 gives 2 bytes and code 3 gives 4 bytes. Code 0 and every other code give 8 bytes.
- R7: A data access of `data_bytes` bytes (1 to 8) at `data_addr` matches when `data_addr` < base + width and `data_addr` + `data_bytes` > base. The comparison uses one extra bit, so it never wraps.
- R8: The outputs show the match result of the inputs at the previous rising clock edge. They do not change between edges.
- R9: When a fetch match and a data match happen in the same cycle, the fetch match is reported with `hit_fetch`=1. A data-only match is reported with `hit_fetch`=0.
- R10: `hit_trig` is one-hot while `hit_valid` is 1 and zero otherwise. When several triggers match in the reported class, the lowest index wins.
- R11: With `fetch_valid` and `data_valid` both 0, no hit is reported in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Current privilege code (0, 1, 3) |
| trig_ctrl | input | NUM_TRIG*XLEN | Control word of each trigger; trigger i is at slice i |
| trig_base | input | NUM_TRIG*XLEN | Base address word of each trigger |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_pc | input | XLEN | Fetch address |
| data_valid | input | 1 | A load/store is presented |
| data_write | input | 1 | 1 for a store, 0 for a load |
| data_addr | input | XLEN | First byte address of the access |
| data_bytes | input | BYTE_W | Access width in bytes, 1 to 8 |
| hit_valid | output | 1 | A breakpoint request is raised |
| hit_fetch | output | 1 | The request comes from a fetch match |
| hit_trig | output | NUM_TRIG | One-hot index of the trigger that fired |

## Verification
Directed patterns target one condition at a time. Some give a trigger privilege bits without access bits, or the reverse. Some put the core in an unselected privilege level or in the unused one. Others present a fetch one byte off its base, or a read against a write-only trigger. Window tests place accesses at the last byte inside and the first byte outside each window width. Other accesses end exactly at the base or cross into it, which separates the overlap rule from a plain start-address compare. Cases where both classes hit, and where both triggers hit, check the fetch-first and lowest-index orderings. A random phase then mixes addresses clustered around the bases with random control words, so that the decode, compare and priority logic are exercised together.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;

    localparam int RD_BIT      = 0;
    localparam int WR_BIT      = 1;
    localparam int EX_BIT      = 2;
    localparam int PRIV_U_BIT  = 3;
    localparam int PRIV_S_BIT  = 4;
    localparam int PRIV_M_BIT  = 6;
    localparam int SZ_LO_BIT   = 16;
    localparam int SZ_HI_BIT   = 21;
    localparam int WIN_W       = 4;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH_HIT = 2'd1,
        ST_DATA_HIT  = 2'd2
    } match_state_e;

    typedef struct packed {
        logic              active;
        logic              priv_ok;
        logic              rd_en;
        logic              wr_en;
        logic              ex_en;
        logic [WIN_W-1:0]  win_bytes;
    } trig_cfg_t;

endpackage

// File: rtl/trig_cfg_decode.sv
module trig_cfg_decode
    import trig_match_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ctrl,
    input  logic [1:0]      priv_lvl,
    output trig_cfg_t       cfg
);

    logic       any_priv;
    logic       any_kind;
    logic [3:0] size_code;

    always_comb begin
        any_priv  = ctrl[PRIV_U_BIT] | ctrl[PRIV_S_BIT] | ctrl[PRIV_M_BIT];
        any_kind  = ctrl[RD_BIT] | ctrl[WR_BIT] | ctrl[EX_BIT];
        size_code = {ctrl[SZ_HI_BIT+1:SZ_HI_BIT], ctrl[SZ_LO_BIT+1:SZ_LO_BIT]};

        cfg.active = any_priv & any_kind;
        cfg.rd_en  = ctrl[RD_BIT];
        cfg.wr_en  = ctrl[WR_BIT];
        cfg.ex_en  = ctrl[EX_BIT];

        unique case (priv_lvl)
            2'd0:    cfg.priv_ok = ctrl[PRIV_U_BIT];
            2'd1:    cfg.priv_ok = ctrl[PRIV_S_BIT];
            2'd3:    cfg.priv_ok = ctrl[PRIV_M_BIT];
            default: cfg.priv_ok = 1'b0;
        endcase

        unique case (size_code)
            4'd1:    cfg.win_bytes = WIN_W'(1);
            4'd2:    cfg.win_bytes = WIN_W'(2);
            4'd3:    cfg.win_bytes = WIN_W'(4);
            default: cfg.win_bytes = WIN_W'(8);
        endcase
    end

endmodule

// File: rtl/trig_addr_cmp.sv
module trig_addr_cmp
    import trig_match_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int BYTE_W = 4
) (
    input  trig_cfg_t       cfg,
    input  logic [XLEN-1:0] base,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            data_valid,
    input  logic            data_write,
    input  logic [XLEN-1:0] data_addr,
    input  logic [BYTE_W-1:0] data_bytes,
    output logic            fetch_hit,
    output logic            data_hit
);

    localparam int EW = XLEN + 1;

    logic [EW-1:0] acc_lo;
    logic [EW-1:0] acc_hi;
    logic [EW-1:0] win_lo;
    logic [EW-1:0] win_hi;
    logic          kind_ok;
    logic          overlap;
    logic          armed;

    always_comb begin
        acc_lo  = {1'b0, data_addr};
        acc_hi  = acc_lo + {{(EW-BYTE_W){1'b0}}, data_bytes};
        win_lo  = {1'b0, base};
        win_hi  = win_lo + {{(EW-WIN_W){1'b0}}, cfg.win_bytes};
        overlap = (acc_lo < win_hi) && (acc_hi > win_lo);
        kind_ok = data_write ? cfg.wr_en : cfg.rd_en;
        armed   = cfg.active & cfg.priv_ok;

        fetch_hit = armed & fetch_valid & cfg.ex_en & (fetch_pc == base);
        data_hit  = armed & data_valid & kind_ok & overlap;
    end

endmodule

// File: rtl/trig_first_one.sv
module trig_first_one #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            if (i == 0) begin : g_head
                assign pick[i] = req[i];
            end else begin : g_tail
                assign pick[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
    import trig_match_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_TRIG = 2,
    parameter int BYTE_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               priv_lvl,
    input  logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
    input  logic [NUM_TRIG*XLEN-1:0] trig_base,
    input  logic                     fetch_valid,
    input  logic [XLEN-1:0]          fetch_pc,
    input  logic                     data_valid,
    input  logic                     data_write,
    input  logic [XLEN-1:0]          data_addr,
    input  logic [BYTE_W-1:0]        data_bytes,
    output logic                     hit_valid,
    output logic                     hit_fetch,
    output logic [NUM_TRIG-1:0]      hit_trig
);

    logic [NUM_TRIG-1:0] fetch_vec;
    logic [NUM_TRIG-1:0] data_vec;
    logic [NUM_TRIG-1:0] fetch_pick;
    logic [NUM_TRIG-1:0] data_pick;

    genvar t;
    generate
        for (t = 0; t < NUM_TRIG; t++) begin : g_trig
            trig_cfg_t cfg;

            trig_cfg_decode #(.XLEN(XLEN)) u_dec (
                .ctrl     (trig_ctrl[t*XLEN +: XLEN]),
                .priv_lvl (priv_lvl),
                .cfg      (cfg)
            );

            trig_addr_cmp #(.XLEN(XLEN), .BYTE_W(BYTE_W)) u_cmp (
                .cfg         (cfg),
                .base        (trig_base[t*XLEN +: XLEN]),
                .fetch_valid (fetch_valid),
                .fetch_pc    (fetch_pc),
                .data_valid  (data_valid),
                .data_write  (data_write),
                .data_addr   (data_addr),
                .data_bytes  (data_bytes),
                .fetch_hit   (fetch_vec[t]),
                .data_hit    (data_vec[t])
            );
        end
    endgenerate

    trig_first_one #(.N(NUM_TRIG)) u_pick_fetch (
        .req  (fetch_vec),
        .pick (fetch_pick)
    );

    trig_first_one #(.N(NUM_TRIG)) u_pick_data (
        .req  (data_vec),
        .pick (data_pick)
    );

    match_state_e        state_q;
    match_state_e        state_d;
    logic [NUM_TRIG-1:0] trig_q;
    logic [NUM_TRIG-1:0] trig_d;

    always_comb begin
        if (|fetch_vec) begin
            state_d = ST_FETCH_HIT;
            trig_d  = fetch_pick;
        end else if (|data_vec) begin
            state_d = ST_DATA_HIT;
            trig_d  = data_pick;
        end else begin
            state_d = ST_IDLE;
            trig_d  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            trig_q  <= '0;
        end else begin
            state_q <= state_d;
            trig_q  <= trig_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FETCH_HIT: begin
                hit_valid = 1'b1;
                hit_fetch = 1'b1;
                hit_trig  = trig_q;
            end
            ST_DATA_HIT: begin
                hit_valid = 1'b1;
                hit_fetch = 1'b0;
                hit_trig  = trig_q;
            end
            default: begin
                hit_valid = 1'b0;
                hit_fetch = 1'b0;
                hit_trig  = '0;
            end
        endcase
    end

endmodule

// File: rtl/trig_match_unit_chk.sv
module trig_match_unit_chk #(
    parameter int NUM_TRIG = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          priv_lvl,
    input logic                fetch_valid,
    input logic                data_valid,
    input logic                hit_valid,
    input logic                hit_fetch,
    input logic [NUM_TRIG-1:0] hit_trig
);

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $countones(hit_trig) == 1);

    assert_quiet_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> hit_trig == '0);

    assert_fetch_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_fetch |-> hit_valid);

    assert_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!fetch_valid && !data_valid) |-> !hit_valid);

    assert_reserved_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(priv_lvl == 2'd2) |-> !hit_valid);

endmodule

bind trig_match_unit trig_match_unit_chk #(.NUM_TRIG(NUM_TRIG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_lvl    (priv_lvl),
    .fetch_valid (fetch_valid),
    .data_valid  (data_valid),
    .hit_valid   (hit_valid),
    .hit_fetch   (hit_fetch),
    .hit_trig    (hit_trig)
);

// File: tb/tb_trig_match_unit.sv
module tb_trig_match_unit;

    localparam int XLEN = 32;
    localparam int N    = 2;
    localparam int BW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      priv_lvl = 2'd3;
    logic [XLEN-1:0] ctrl0 = '0, ctrl1 = '0, base0 = '0, base1 = '0;
    logic            fetch_valid = 1'b0;
    logic [XLEN-1:0] fetch_pc = '0;
    logic            data_valid = 1'b0;
    logic            data_write = 1'b0;
    logic [XLEN-1:0] data_addr = '0;
    logic [BW-1:0]   data_bytes = 4'd1;
    logic            hit_valid, hit_fetch;
    logic [N-1:0]    hit_trig;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    trig_match_unit #(.XLEN(XLEN), .NUM_TRIG(N), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl),
        .trig_ctrl({ctrl1, ctrl0}), .trig_base({base1, base0}),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .data_valid(data_valid), .data_write(data_write),
        .data_addr(data_addr), .data_bytes(data_bytes),
        .hit_valid(hit_valid), .hit_fetch(hit_fetch), .hit_trig(hit_trig)
    );

    // size code: 1->1, 2->2, 3->4, anything else 8 bytes; code[3:2] at ctrl[22:21], code[1:0] at ctrl[17:16]
    function automatic logic [XLEN-1:0] mk(bit u, bit s, bit m, bit rd, bit wr, bit ex, logic [3:0] code);
        logic [XLEN-1:0] c = '0;
        c[0] = rd; c[1] = wr; c[2] = ex;
        c[3] = u;  c[4] = s;  c[6] = m;
        c[17:16] = code[1:0];
        c[22:21] = code[3:2];
        return c;
    endfunction

    function automatic bit priv_en(logic [XLEN-1:0] c, logic [1:0] p);
        case (p)
            2'd0: return c[3];
            2'd1: return c[4];
            2'd3: return c[6];
            default: return 1'b0;
        endcase
    endfunction

    function automatic longint unsigned wbytes(logic [XLEN-1:0] c);
        case ({c[22:21], c[17:16]})
            4'd1: return 1;
            4'd2: return 2;
            4'd3: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [3:0] model();
        logic [N-1:0] fh = '0, dh = '0;
        for (int t = 0; t < N; t++) begin
            logic [XLEN-1:0] c = (t == 0) ? ctrl0 : ctrl1;
            logic [XLEN-1:0] a = (t == 0) ? base0 : base1;
            bit act = (c[3] | c[4] | c[6]) & (c[0] | c[1] | c[2]) & priv_en(c, priv_lvl);
            longint unsigned lo = data_addr;
            longint unsigned hi = lo + data_bytes;
            longint unsigned wl = a;
            longint unsigned wh = wl + wbytes(c);
            fh[t] = act && fetch_valid && c[2] && (fetch_pc == a);
            dh[t] = act && data_valid && (data_write ? c[1] : c[0]) && (lo < wh) && (hi > wl);
        end
        if (fh != 0) return {2'b11, fh[0] ? 2'b01 : 2'b10};
        if (dh != 0) return {2'b10, dh[0] ? 2'b01 : 2'b10};
        return 4'b0000;
    endfunction

    task automatic check(string tag, logic [3:0] exp);
        n_chk++;
        if ({hit_valid, hit_fetch, hit_trig} !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid/fetch/trig=%b expected %b", tag,
                     {hit_valid, hit_fetch, hit_trig}, exp);
        end
    endtask

    task automatic apply(string tag);
        logic [3:0] exp = model();
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic idle();
        fetch_valid = 1'b0;
        data_valid  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        base0 = 32'h0000_1000;
        base1 = 32'h0000_2000;
        repeat (3) @(negedge clk);
        check("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        apply("R1 after reset");

        // R2: access bits without privilege bits, then the reverse
        ctrl0 = mk(0,0,0,1,1,1,4'd0);
        fetch_valid = 1; fetch_pc = base0; data_valid = 1; data_addr = base0; data_bytes = 4;
        apply("R2 no priv bits");
        ctrl0 = mk(1,1,1,0,0,0,4'd0);
        apply("R2 no access bits");
        idle();

        // R4 exact fetch match
        ctrl0 = mk(0,0,1,0,0,1,4'd0);
        fetch_valid = 1; fetch_pc = base0;
        apply("R4 exact pc");
        fetch_pc = base0 + 1;
        apply("R4 pc off by one");

        // R3 privilege selection
        fetch_pc = base0;
        ctrl0 = mk(1,0,0,0,0,1,4'd0); priv_lvl = 2'd1;
        apply("R3 S mode with only U bit");
        ctrl0 = mk(0,1,0,0,0,1,4'd0);
        apply("R3 S mode with S bit");
        ctrl0 = mk(1,1,1,0,0,1,4'd0); priv_lvl = 2'd2;
        apply("R3 reserved privilege");
        priv_lvl = 2'd0;
        apply("R3 U mode");
        priv_lvl = 2'd3;
        idle();

        // R5 read/write selection
        ctrl0 = mk(0,0,1,1,0,0,4'd3);
        data_valid = 1; data_addr = base0; data_bytes = 1; data_write = 1;
        apply("R5 write on read-only trigger");
        data_write = 0;
        apply("R5 read on read trigger");
        ctrl0 = mk(0,0,1,0,1,0,4'd3); data_write = 1;
        apply("R5 write on write trigger");
        data_write = 0;

        // R6 window widths
        ctrl0 = mk(0,0,1,1,0,0,4'd1); data_addr = base0 + 1;
        apply("R6 code1 one past window");
        data_addr = base0;
        apply("R6 code1 inside");
        ctrl0 = mk(0,0,1,1,0,0,4'd2); data_addr = base0 + 1;
        apply("R6 code2 last byte");
        data_addr = base0 + 2;
        apply("R6 code2 past window");
        ctrl0 = mk(0,0,1,1,0,0,4'd3); data_addr = base0 + 3;
        apply("R6 code3 last byte");
        data_addr = base0 + 4;
        apply("R6 code3 past window");
        ctrl0 = mk(0,0,1,1,0,0,4'd0); data_addr = base0 + 7;
        apply("R6 code0 last byte");
        data_addr = base0 + 8;
        apply("R6 code0 past window");
        ctrl0 = mk(0,0,1,1,0,0,4'd6); data_addr = base0 + 7;
        apply("R6 unsupported code as 8 bytes");

        // R7 overlap from below, and the wrap corner
        ctrl0 = mk(0,0,1,1,0,0,4'd1); data_bytes = 4;
        data_addr = base0 - 3;
        apply("R7 access crosses into base");
        data_addr = base0 - 4;
        apply("R7 access ends at base");
        base1 = 32'hFFFF_FFFC; ctrl1 = mk(0,0,1,1,0,0,4'd0); data_bytes = 8;
        data_addr = 32'hFFFF_FFFE;
        apply("R7 no wrap at top");
        data_addr = 32'h0000_0000; ctrl0 = '0;
        apply("R7 low address vs top window");
        base1 = 32'h0000_2000; data_bytes = 1;
        idle();

        // R9 fetch priority; R10 lowest index
        ctrl0 = mk(0,0,1,1,0,0,4'd0);
        ctrl1 = mk(0,0,1,0,0,1,4'd0);
        fetch_valid = 1; fetch_pc = base1;
        data_valid = 1; data_addr = base0; data_write = 0;
        apply("R9 fetch beats data");
        fetch_valid = 0;
        apply("R9 data only");
        ctrl1 = mk(0,0,1,1,0,0,4'd0); base1 = base0 + 2;
        apply("R10 both data triggers");
        idle();
        apply("R11 nothing valid");

        // R8 registered output
        data_valid = 1; data_addr = base0;
        #2;
        check("R8 before edge", 4'b0000);
        @(negedge clk);
        check("R8 after edge", 4'b1001);
        idle();
        apply("R8 drops");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] code = 4'($urandom % 8);
            logic [3:0] b = 4'($urandom);
            ctrl0 = mk(b[0], b[1], b[2], $urandom%2, $urandom%2, $urandom%2, code);
            ctrl1 = mk($urandom%2, $urandom%2, $urandom%2, $urandom%2, $urandom%2, $urandom%2, 4'($urandom % 8));
            base0 = 32'h0000_4000 + 32'($urandom % 16);
            base1 = 32'h0000_4000 + 32'($urandom % 16);
            priv_lvl = 2'($urandom);
            fetch_valid = ($urandom % 4) != 0;
            fetch_pc = 32'h0000_4000 + 32'($urandom % 16);
            data_valid = ($urandom % 4) != 0;
            data_write = $urandom % 2;
            data_addr = 32'h0000_3FF4 + 32'($urandom % 36);
            data_bytes = 4'(1 + $urandom % 8);
            apply("random R2 R3 R4 R5 R6 R7 R9 R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule